// File: doc/BRIEF.md
# Call Progress Tone Synthesizer

This block produces the audible status tones a switching system plays toward a caller, such as dial tone, ringback and reorder. It runs from a 3.579545 MHz reference clock and emits a signed 12-bit sample stream at a fixed rate of `CLK_HZ / SAMPLE_DIV`. A separate converter turns that stream into an analog signal. A 4-bit selection code picks either one frequency or a pair of frequencies. Each frequency has its own phase accumulator and sine lookup, and the two waveforms are added to form the sample.

The enable input is active low and reacts to edges. The clock edge that first sees it low after it was high captures the selection code. That edge also clears both phase accumulators and starts the burst. The tone continues for as long as the enable stays low. Changes on the code lines after the capture edge have no effect on the tone. Driving the enable high ends the burst. A status output is high while a tone is being produced. A one-cycle strobe marks each new sample.

Top module: `cpt_synth`

## Requirements
- R1: The captured code selects the frequencies as follows. 0000 gives 350+440 Hz. 0001 gives 400 Hz alone. 0010 gives 440 Hz alone. 0011 gives 440+480 Hz. 0100 gives 440+620 Hz. 0101 gives 480 Hz alone. 0110 gives 480+620 Hz. 0111 gives 350 Hz alone. 1000 gives 620 Hz alone. 1001 gives 941+1209 Hz.
- R2: Each tone has a PHASE_W-bit phase. Once per sample period, the phase advances by round(f * 2^PHASE_W * SAMPLE_DIV / CLK_HZ). The tone's value is round(1023 * sin((n + 0.5) * 2*pi / 64)), where n is the top 6 phase bits. The output sample is the sum of the active tones' values.
- R3: The output sample never exceeds 2044 in magnitude, so it always fits in 12 signed bits.
- R4: The code is captured only at a clock edge that sees the enable low after the previous edge saw it high. An enable that is already low when reset is released starts no tone.
- R5: After the capture edge, changes on the code lines do not alter the tone that is playing.
- R6: Once an edge samples the enable high, the status output and the sample are zero from the following edge onward.
- R7: While a burst runs, the strobe pulses for one cycle every SAMPLE_DIV clocks. The first pulse comes one clock after the capture edge.
- R8: Codes 1010 through 1111 produce a zero sample and keep the status output low.
- R9: A synchronous active-high reset clears the captured code, ends any burst, and zeroes the sample, the strobe and the status output.
- R10: Every burst starts at zero phase. The first strobed sample is 100 for a pair of tones and 50 for a single tone.
- R11: The status output is high while a burst with an assigned code runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (3.579545 MHz by default) |
| rst | input | 1 | Synchronous reset, active high |
| cen_n | input | 1 | Burst enable, active low, captures the code on its falling edge |
| code_in | input | 4 | Tone selection code |
| sample_out | output | 12 | Signed sum of the active tones |
| sample_stb | output | 1 | One-cycle pulse marking a new sample |
| tone_on | output | 1 | High while a tone is being produced |

## Verification
Every one of the sixteen codes is played as a burst. A cycle-accurate reference model compares the sample, the strobe and the status output on every cycle. Together these separate correct pairs from single tones, and assigned codes from silent ones. The model computes its phase steps and sine values with real arithmetic, so an error in a frequency constant or a table entry shows up as a sample mismatch within a few periods. In each burst the code lines are flipped to the complement of the captured code. This would expose a capture that is transparent rather than edge-held. The first strobed sample after each capture shows whether the phase restarted at zero. The enable is also held low through reset. This tells an edge-triggered capture apart from a level-sensitive one.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

  localparam int CODE_W    = 4;
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int LUT_ABITS = 6;
  localparam int QTR_ABITS = LUT_ABITS - 2;
  localparam int WAVE_W    = 12;
  localparam int HZ_W      = 11;
  localparam int PEAK_SUM  = 2044;

  typedef longint unsigned u64_t;

  typedef struct packed {
    logic [HZ_W-1:0] hz_a;
    logic [HZ_W-1:0] hz_b;
  } tone_pair_t;

  // Frequency pair per selection code; zero means that voice is silent.
  function automatic tone_pair_t tone_lookup(input logic [CODE_W-1:0] c);
    tone_pair_t p;
    case (c)
      4'd0:    p = '{hz_a: 11'd350, hz_b: 11'd440};
      4'd1:    p = '{hz_a: 11'd400, hz_b: 11'd0};
      4'd2:    p = '{hz_a: 11'd440, hz_b: 11'd0};
      4'd3:    p = '{hz_a: 11'd440, hz_b: 11'd480};
      4'd4:    p = '{hz_a: 11'd440, hz_b: 11'd620};
      4'd5:    p = '{hz_a: 11'd480, hz_b: 11'd0};
      4'd6:    p = '{hz_a: 11'd480, hz_b: 11'd620};
      4'd7:    p = '{hz_a: 11'd350, hz_b: 11'd0};
      4'd8:    p = '{hz_a: 11'd620, hz_b: 11'd0};
      4'd9:    p = '{hz_a: 11'd941, hz_b: 11'd1209};
      default: p = '{hz_a: 11'd0,   hz_b: 11'd0};
    endcase
    return p;
  endfunction

  // Phase step per sample period: round(hz * 2^pw * div / clk_hz).
  function automatic logic [31:0] hz_to_step(input int unsigned hz, input int unsigned clk_hz,
                                             input int unsigned div, input int unsigned pw);
    u64_t num;
    num = (u64_t'(hz) * u64_t'(div)) << pw;
    return 32'((num + u64_t'(clk_hz / 2)) / u64_t'(clk_hz));
  endfunction

  // First quadrant magnitudes: round(1023 * sin((i + 0.5) * pi / 32)).
  function automatic logic [9:0] quarter_mag(input logic [QTR_ABITS-1:0] i);
    logic [9:0] m;
    case (i)
      4'd0:  m = 10'd50;
      4'd1:  m = 10'd150;
      4'd2:  m = 10'd249;
      4'd3:  m = 10'd345;
      4'd4:  m = 10'd437;
      4'd5:  m = 10'd526;
      4'd6:  m = 10'd609;
      4'd7:  m = 10'd687;
      4'd8:  m = 10'd758;
      4'd9:  m = 10'd822;
      4'd10: m = 10'd877;
      4'd11: m = 10'd925;
      4'd12: m = 10'd963;
      4'd13: m = 10'd992;
      4'd14: m = 10'd1012;
      default: m = 10'd1022;
    endcase
    return m;
  endfunction

  // Full wave from the quarter table by mirroring and negation.
  function automatic logic signed [WAVE_W-1:0] wave_at(input logic [LUT_ABITS-1:0] p);
    logic [1:0]           quad;
    logic [QTR_ABITS-1:0] idx;
    logic [WAVE_W-1:0]    mag;
    quad = p[LUT_ABITS-1 -: 2];
    idx  = p[QTR_ABITS-1:0];
    mag  = {2'b00, quarter_mag(quad[0] ? ~idx : idx)};
    return quad[1] ? -$signed(mag) : $signed(mag);
  endfunction

endpackage

// File: rtl/cpt_ctrl.sv
module cpt_ctrl
  import cpt_pkg::*;
#(
  parameter int SAMPLE_DIV = 448
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cen_n,
  input  logic [CODE_W-1:0] code_in,
  output logic              active,
  output logic [CODE_W-1:0] code_q,
  output logic              fall_evt,
  output logic              tick,
  output logic              frame_start
);

  localparam int CNT_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_DIV - 1);

  logic             cen_d;
  logic [CNT_W-1:0] cnt;
  logic             cnt_last;

  assign fall_evt    = cen_d & ~cen_n;
  assign cnt_last    = (cnt == CNT_LAST);
  assign tick        = active & cnt_last & ~cen_n;
  assign frame_start = active & (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cen_d  <= 1'b0;
      active <= 1'b0;
      code_q <= '0;
      cnt    <= '0;
    end else begin
      cen_d <= cen_n;
      if (fall_evt) begin
        active <= 1'b1;
        code_q <= code_in;
        cnt    <= '0;
      end else if (cen_n) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (active) begin
        cnt <= cnt_last ? '0 : cnt + 1'b1;
      end
    end
  end

  assert_capture_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    fall_evt |=> (active && code_q == $past(code_in)));

  assert_release_stops_R6: assert property (@(posedge clk) disable iff (rst)
    cen_n |=> !active);

  assert_code_held_R5: assert property (@(posedge clk) disable iff (rst)
    (active && !cen_n) |=> $stable(code_q));

endmodule

// File: rtl/cpt_nco.sv
module cpt_nco
  import cpt_pkg::*;
#(
  parameter int PHASE_W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     adv,
  input  logic [PHASE_W-1:0]       step,
  output logic [PHASE_W-1:0]       phase,
  output logic signed [WAVE_W-1:0] wave
);

  always_ff @(posedge clk) begin
    if (rst || clr) phase <= '0;
    else if (adv)   phase <= phase + step;
  end

  assign wave = wave_at(phase[PHASE_W-1 -: LUT_ABITS]);

  assert_zero_phase_start_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (phase == '0));

  assert_phase_moves_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(phase));

endmodule

// File: rtl/cpt_mix.sv
module cpt_mix
  import cpt_pkg::*;
#(
  parameter int SAMPLE_DIV = 448
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     active,
  input  logic [CODE_W-1:0]        code_q,
  input  logic                     frame_start,
  input  logic signed [WAVE_W-1:0] wave_a,
  input  logic signed [WAVE_W-1:0] wave_b,
  output logic signed [WAVE_W-1:0] sample_out,
  output logic                     sample_stb,
  output logic                     tone_on
);

  tone_pair_t              pair;
  logic                    code_ok;
  logic                    b_on;
  logic signed [WAVE_W-1:0] sum;

  always_comb begin
    pair    = tone_lookup(code_q);
    code_ok = (pair.hz_a != '0);
    b_on    = (pair.hz_b != '0);
    sum     = wave_a + (b_on ? wave_b : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_out <= '0;
      sample_stb <= 1'b0;
      tone_on    <= 1'b0;
    end else begin
      tone_on    <= active & code_ok;
      sample_out <= (active & code_ok) ? sum : '0;
      sample_stb <= frame_start;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (sample_out <= 12'sd2044) && (sample_out >= -12'sd2044));

  assert_silent_when_off_R6: assert property (@(posedge clk) disable iff (rst)
    !tone_on |-> (sample_out == '0));

  assert_unassigned_silent_R8: assert property (@(posedge clk) disable iff (rst)
    tone_on |-> ($past(code_q) < 4'd10));

  generate
    if (SAMPLE_DIV > 1) begin : g_stb_chk
      assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb);
    end
  endgenerate

endmodule

// File: rtl/cpt_synth.sv
module cpt_synth
  import cpt_pkg::*;
#(
  parameter int CLK_HZ     = 3579545,
  parameter int SAMPLE_DIV = 448,
  parameter int PHASE_W    = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cen_n,
  input  logic [CODE_W-1:0]        code_in,
  output logic signed [WAVE_W-1:0] sample_out,
  output logic                     sample_stb,
  output logic                     tone_on
);

  localparam int NUM_VOICES = 2;

  logic                     active;
  logic [CODE_W-1:0]        code_q;
  logic                     fall_evt;
  logic                     tick;
  logic                     frame_start;
  logic [PHASE_W-1:0]       step_tab [NUM_VOICES][NUM_CODES];
  logic [PHASE_W-1:0]       phase_v  [NUM_VOICES];
  logic signed [WAVE_W-1:0] wave_v   [NUM_VOICES];

  cpt_ctrl #(.SAMPLE_DIV(SAMPLE_DIV)) ctrl_i (
    .clk(clk), .rst(rst), .cen_n(cen_n), .code_in(code_in),
    .active(active), .code_q(code_q), .fall_evt(fall_evt),
    .tick(tick), .frame_start(frame_start)
  );

  // Phase steps are elaboration-time constants, one per code and voice.
  generate
    for (genvar c = 0; c < NUM_CODES; c++) begin : g_step
      localparam tone_pair_t PR = tone_lookup(CODE_W'(c));
      assign step_tab[0][c] = PHASE_W'(hz_to_step(32'(PR.hz_a), CLK_HZ, SAMPLE_DIV, PHASE_W));
      assign step_tab[1][c] = PHASE_W'(hz_to_step(32'(PR.hz_b), CLK_HZ, SAMPLE_DIV, PHASE_W));
    end

    for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
      cpt_nco #(.PHASE_W(PHASE_W)) nco_i (
        .clk(clk), .rst(rst), .clr(fall_evt), .adv(tick),
        .step(step_tab[v][code_q]), .phase(phase_v[v]), .wave(wave_v[v])
      );
    end
  endgenerate

  cpt_mix #(.SAMPLE_DIV(SAMPLE_DIV)) mix_i (
    .clk(clk), .rst(rst), .active(active), .code_q(code_q),
    .frame_start(frame_start), .wave_a(wave_v[0]), .wave_b(wave_v[1]),
    .sample_out(sample_out), .sample_stb(sample_stb), .tone_on(tone_on)
  );

  assert_phases_restart_R10: assert property (@(posedge clk) disable iff (rst)
    fall_evt |=> (phase_v[0] == '0 && phase_v[1] == '0));

endmodule

// File: tb/cpt_synth_tb.sv
`timescale 1ns/1ps
module cpt_synth_tb_top;

  localparam int    TB_DIV  = 32;
  localparam int    TB_PW   = 24;
  localparam int    TB_CLK  = 3579545;
  localparam int    BURST   = 3000;
  localparam real   TWO_PI  = 6.283185307179586;
  localparam longint PMASK  = (64'd1 << TB_PW) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cen_n = 1'b1;
  logic [3:0]        code_in = 4'd0;
  logic signed [11:0] sample_out;
  logic              sample_stb;
  logic              tone_on;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit seen_edge = 1'b0;
  int max_mag = 0;

  always #2.5 clk = ~clk;

  cpt_synth #(.CLK_HZ(TB_CLK), .SAMPLE_DIV(TB_DIV), .PHASE_W(TB_PW)) dut_i (
    .clk(clk), .rst(rst), .cen_n(cen_n), .code_in(code_in),
    .sample_out(sample_out), .sample_stb(sample_stb), .tone_on(tone_on)
  );

  // Frequency plan restated as two lists (R1).
  function automatic int hz_low(int c);
    int t [10] = '{350, 400, 440, 440, 440, 480, 480, 350, 620, 941};
    return (c < 10) ? t[c] : 0;
  endfunction
  function automatic int hz_high(int c);
    int t [10] = '{440, 0, 0, 480, 620, 0, 620, 0, 0, 1209};
    return (c < 10) ? t[c] : 0;
  endfunction
  function automatic longint step_of(int hz);
    return longint'($rtoi(real'(hz) * TB_DIV * (2.0 ** TB_PW) / TB_CLK + 0.5));
  endfunction
  function automatic int wave_ref(longint ph);
    int  n;
    real r;
    int  mag;
    n   = int'(ph >> (TB_PW - 6));
    r   = 1023.0 * $sin((n + 0.5) * TWO_PI / 64.0);
    mag = $rtoi((r < 0.0 ? -r : r) + 0.5);
    return (r < 0.0) ? -mag : mag;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model
  bit     m_cen_d, m_active, m_stb, m_on;
  int     m_code, m_cnt, m_sample;
  longint m_pa, m_pb;

  always @(posedge clk) begin
    seen_edge <= 1'b1;
    if (rst) begin
      m_cen_d = 0; m_active = 0; m_code = 0; m_cnt = 0;
      m_pa = 0; m_pb = 0; m_stb = 0; m_on = 0; m_sample = 0;
    end else begin
      int  ha, hb, nxt_sample;
      bit  nxt_on, nxt_stb;
      ha = hz_low(m_code);
      hb = hz_high(m_code);
      nxt_on     = m_active && (ha != 0);
      nxt_sample = nxt_on ? wave_ref(m_pa) + ((hb != 0) ? wave_ref(m_pb) : 0) : 0;
      nxt_stb    = m_active && (m_cnt == 0);
      if (m_cen_d && !cen_n) begin
        m_active = 1; m_code = int'(code_in); m_cnt = 0; m_pa = 0; m_pb = 0;
      end else if (cen_n) begin
        m_active = 0; m_cnt = 0;
      end else if (m_active) begin
        if (m_cnt == TB_DIV - 1) begin
          m_cnt = 0;
          m_pa  = (m_pa + step_of(ha)) & PMASK;
          m_pb  = (m_pb + step_of(hb)) & PMASK;
        end else m_cnt++;
      end
      m_cen_d  = cen_n;
      m_on     = nxt_on;
      m_stb    = nxt_stb;
      m_sample = nxt_sample;
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (seen_edge && !done) begin
      int s;
      s = int'(sample_out);
      check(s == m_sample, "R1,R2", "sample", s, m_sample);
      check(sample_stb == m_stb, "R7", "strobe", int'(sample_stb), int'(m_stb));
      check(tone_on == m_on, "R11", "status", int'(tone_on), int'(m_on));
      if (s > max_mag) max_mag = s;
      if (-s > max_mag) max_mag = -s;
    end
  end

  task automatic nwait(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    cen_n = 1'b0;                 // enable low throughout reset
    nwait(4);
    check(sample_out == 0 && sample_stb == 0 && tone_on == 0, "R9", "reset outputs",
          int'(sample_out), 0);
    rst = 1'b0;
    nwait(50);
    check(tone_on == 0, "R4", "no tone without falling edge", int'(tone_on), 0);
    check(sample_out == 0, "R4", "silent without falling edge", int'(sample_out), 0);
    cen_n = 1'b1;
    nwait(3);

    for (int c = 0; c < 16; c++) begin
      bit ok, pair;
      int first;
      ok    = hz_low(c) != 0;
      pair  = hz_high(c) != 0;
      first = ok ? (pair ? 100 : 50) : 0;
      code_in = 4'(c);
      nwait(1);
      cen_n = 1'b0;               // capture at next edge
      @(posedge clk); @(posedge clk); @(negedge clk);
      check(sample_stb == 1, "R7", "first strobe", int'(sample_stb), 1);
      check(int'(sample_out) == first, "R10", "zero-phase first sample", int'(sample_out), first);
      if (ok) check(tone_on == 1, "R11", "status during burst", int'(tone_on), 1);
      else    check(tone_on == 0, "R8", "unassigned code status", int'(tone_on), 0);
      nwait(5);
      code_in = ~4'(c);           // data changes after capture
      nwait(BURST);
      check(tone_on == ok, "R5", "status after data change", int'(tone_on), int'(ok));
      if (!ok) check(sample_out == 0, "R8", "unassigned code sample", int'(sample_out), 0);
      cen_n = 1'b1;
      nwait(2);
      check(tone_on == 0 && sample_out == 0, "R6", "release silences", int'(tone_on), 0);
      nwait(10);
    end

    check(max_mag <= 2044, "R3", "peak magnitude", max_mag, 2044);
    check(max_mag > 1900, "R3", "pair reaches near full scale", max_mag, 1901);

    // R9: reset during a burst
    code_in = 4'd3;
    nwait(1);
    cen_n = 1'b0;
    nwait(200);
    rst = 1'b1;
    nwait(2);
    check(tone_on == 0 && sample_out == 0 && sample_stb == 0, "R9", "reset mid-burst",
          int'(tone_on), 0);
    rst = 1'b0;
    nwait(40);
    check(tone_on == 0, "R4", "held enable after reset stays silent", int'(tone_on), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule